// File: doc/BRIEF.md
# Multi-level page table walker

This block turns a virtual address into a leaf page table entry by walking a
tree of tables held in physical memory. A caller pulses `start` with the
address, the access kind and the current privilege level. The walker picks one
of two root base registers from the top address bit, then visits up to four
table levels from the highest down. At each level it forms an entry address
from the current base and an index field cut out of the virtual address, reads
one 64-bit word, and uses it as the base of the next level. The word read at
the lowest level is the leaf entry.

The leaf goes to an attached permission checker. The checker produces a result
code, the physical address and the write and execute rights. The walk reports
`done` for a single cycle. In that cycle the code, the leaf, the page-size
exponent and the physical address are valid. Each level has its own bit offset
and width, set on configuration inputs. An upper level with width zero is
passed over without a memory read, so trees of one to four levels share one
datapath.

The controller has five states:

- IDLE: waits for `start`. The transition `launch` latches the request and selects the root.
- SEEK: chooses the level. The transition `skip` steps past a zero-width upper level. The transition `fetch` goes on to issue a read.
- REQ: drives the one-cycle read request. The transition `issue` always leads to WAIT.
- WAIT: waits for the response. The transition `descend` returns to SEEK for the next level. The transition `finish` stores the leaf and moves to DONE.
- DONE: raises `done`. The transition `retire` returns to IDLE.

Top module: `ptw_walker`

## Requirements
- R1: When `start` is accepted in IDLE, the walk begins from `root_hi` if `vaddr[63]` is 1 and from `root_lo` otherwise. The low 12 bits of the chosen root are forced to zero.
- R2: Each read address is the current base plus 8 times the index. The index is `(vaddr >> off) & ((1 << wid) - 1)` for the level being visited, and the sum is truncated to PA_W bits. Every read address is therefore 8-byte aligned.
- R3: Levels are visited from 3 down to 0. Level k uses the offset and width held in bits [6k+5:6k] of `lvl_off` and `lvl_wid`. An upper level (3, 2 or 1) whose width is zero issues no read. Level 0 is always read.
- R4: A word read at an upper level becomes the next base, truncated to PA_W bits with its low 12 bits cleared. The word read at level 0 is presented on `leaf_pte` unmodified.
- R5: Only one read is outstanding at any time. `mem_req` is a one-cycle pulse, and no new request is made until `mem_rvalid` has returned the previous one.
- R6: `done` is high for exactly one cycle per walk. In that cycle `page_shift` equals the level 0 offset.
- R7: `result` is decided in the following priority order. Encodings: 0 OK, 1 INVALID, 2 NOEXEC, 3 NOREAD, 4 PRIV, 5 NODIRTY. Access encodings: 0 load, 1 store, 2 fetch.
  - leaf bit 0 (valid) clear gives 1.
  - fetch with leaf bit 62 (no-execute) set gives 2.
  - load with leaf bit 61 (no-read) set gives 3.
  - a privilege violation (R8) gives 4.
  - store with leaf bit 1 (dirty) clear gives 5.
  - anything else gives 0.
- R8: With leaf bit 63 clear, a privilege violation is `priv` greater than leaf bits [3:2]. With leaf bit 63 set, it is `priv` not equal to leaf bits [3:2].
- R9: `phys_addr` takes bits [PA_W-1:page_shift] from the leaf and the bits below `page_shift` from `vaddr`. `can_write` equals leaf bit 1, and `can_exec` equals the inverse of leaf bit 62.
- R10: After reset the walker is in IDLE, with `done` and `mem_req` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (accepted in IDLE) |
| vaddr | input | 64 | Virtual address to resolve |
| access | input | 2 | Access kind: 0 load, 1 store, 2 fetch |
| priv | input | 2 | Current privilege level |
| root_lo | input | PA_W | Root base for addresses with bit 63 clear |
| root_hi | input | PA_W | Root base for addresses with bit 63 set |
| lvl_off | input | 4*6 | Per-level index bit offset, level k at [6k+5:6k] |
| lvl_wid | input | 4*6 | Per-level index width, level k at [6k+5:6k] |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | PA_W | Read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read response data |
| done | output | 1 | Walk complete, one cycle |
| result | output | 3 | Permission check result code |
| leaf_pte | output | 64 | Leaf entry read at level 0 |
| page_shift | output | 6 | Page-size exponent |
| phys_addr | output | PA_W | Translated physical address |
| can_write | output | 1 | Leaf grants write |
| can_exec | output | 1 | Leaf grants execute |

## Verification
The bench builds the walker with its defaults: PA_W of 48 and four levels. It then programs three level layouts at run time:

- a full four-level tree with 4 KiB pages;
- a two-level tree with 16 KiB pages, in which levels 3 and 2 are skipped;
- a tree whose skipped level sits between two active ones.

With those, every combination of access kind, privilege, leaf privilege, privilege mode bit and the four flag bits can be swept exhaustively. Addresses on both sides of bit 63 are also swept, under response latencies from one to three cycles. Directory words carry set low bits and bits above PA_W, so the base clearing and truncation are observable in the read addresses.

// File: rtl/ptw_pkg.sv
package ptw_pkg;
    localparam int unsigned SH_W = 6;

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'd0,
        ACC_STORE = 2'd1,
        ACC_FETCH = 2'd2
    } acc_e;

    typedef enum logic [2:0] {
        RES_OK      = 3'd0,
        RES_INVALID = 3'd1,
        RES_NOEXEC  = 3'd2,
        RES_NOREAD  = 3'd3,
        RES_PRIV    = 3'd4,
        RES_NODIRTY = 3'd5
    } res_e;

    // leaf entry bit positions decoded by the permission checker
    localparam int unsigned PTE_VALID = 0;
    localparam int unsigned PTE_DIRTY = 1;
    localparam int unsigned PTE_PLV   = 2;
    localparam int unsigned PTE_NORD  = 61;
    localparam int unsigned PTE_NOEX  = 62;
    localparam int unsigned PTE_EXACT = 63;
endpackage

// File: rtl/ptw_entry_addr.sv
module ptw_entry_addr #(
    parameter int unsigned PA_W = 48
) (
    input  logic [63:0]              va,
    input  logic [PA_W-1:0]          base,
    input  logic [ptw_pkg::SH_W-1:0] off,
    input  logic [ptw_pkg::SH_W-1:0] wid,
    output logic [PA_W-1:0]          addr
);
    logic [63:0] field;
    logic [63:0] mask;
    logic [63:0] idx;

    always_comb begin
        field = va >> off;
        mask  = (64'd1 << wid) - 64'd1;
        idx   = field & mask;
        addr  = base + PA_W'(idx << 3);
    end
endmodule

// File: rtl/ptw_pte_check.sv
module ptw_pte_check #(
    parameter int unsigned PA_W = 48
) (
    input  logic [63:0]              pte,
    input  logic [PA_W-1:0]          va,
    input  logic [ptw_pkg::SH_W-1:0] shift,
    input  logic [1:0]               acc,
    input  logic [1:0]               plv,
    output logic [2:0]               code,
    output logic [PA_W-1:0]          pa,
    output logic                     wr_ok,
    output logic                     ex_ok
);
    import ptw_pkg::*;

    logic [1:0]      pte_plv;
    logic            priv_bad;
    logic [PA_W-1:0] mask;
    res_e            res;
    logic            unused_pte_bits;

    assign unused_pte_bits = ^pte[60:PA_W];

    always_comb begin
        pte_plv  = pte[PTE_PLV +: 2];
        priv_bad = pte[PTE_EXACT] ? (plv != pte_plv) : (plv > pte_plv);
        if (!pte[PTE_VALID])                                res = RES_INVALID;
        else if (acc == ACC_FETCH && pte[PTE_NOEX])         res = RES_NOEXEC;
        else if (acc == ACC_LOAD && pte[PTE_NORD])          res = RES_NOREAD;
        else if (priv_bad)                                  res = RES_PRIV;
        else if (acc == ACC_STORE && !pte[PTE_DIRTY])       res = RES_NODIRTY;
        else                                                res = RES_OK;
        code  = res;
        mask  = (PA_W'(1) << shift) - PA_W'(1);
        pa    = (pte[PA_W-1:0] & ~mask) | (va & mask);
        wr_ok = pte[PTE_DIRTY];
        ex_ok = !pte[PTE_NOEX];
    end
endmodule

// File: rtl/ptw_walker.sv
module ptw_walker #(
    parameter int unsigned PA_W   = 48,
    parameter int unsigned LEVELS = 4
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              start,
    input  logic [63:0]                       vaddr,
    input  logic [1:0]                        access,
    input  logic [1:0]                        priv,
    input  logic [PA_W-1:0]                   root_lo,
    input  logic [PA_W-1:0]                   root_hi,
    input  logic [LEVELS*ptw_pkg::SH_W-1:0]   lvl_off,
    input  logic [LEVELS*ptw_pkg::SH_W-1:0]   lvl_wid,
    output logic                              mem_req,
    output logic [PA_W-1:0]                   mem_addr,
    input  logic                              mem_rvalid,
    input  logic [63:0]                       mem_rdata,
    output logic                              done,
    output logic [2:0]                        result,
    output logic [63:0]                       leaf_pte,
    output logic [ptw_pkg::SH_W-1:0]          page_shift,
    output logic [PA_W-1:0]                   phys_addr,
    output logic                              can_write,
    output logic                              can_exec
);
    import ptw_pkg::*;

    localparam int unsigned LV_W   = (LEVELS > 1) ? $clog2(LEVELS) : 1;
    localparam int unsigned PG_LOW = 12;

    typedef enum logic [2:0] {
        S_IDLE, S_SEEK, S_REQ, S_WAIT, S_DONE
    } state_e;

    state_e          state_q, state_d;
    logic [63:0]     va_q;
    logic [1:0]      acc_q, plv_q;
    logic [PA_W-1:0] base_q;
    logic [LV_W-1:0] lvl_q;
    logic [63:0]     leaf_q;
    logic [SH_W-1:0] off_cur, wid_cur;
    logic            skip_lvl;

    assign off_cur  = lvl_off[lvl_q*SH_W +: SH_W];
    assign wid_cur  = lvl_wid[lvl_q*SH_W +: SH_W];
    assign skip_lvl = (lvl_q != '0) && (wid_cur == '0);

    ptw_entry_addr #(.PA_W(PA_W)) u_addr (
        .va   (va_q),
        .base (base_q),
        .off  (off_cur),
        .wid  (wid_cur),
        .addr (mem_addr)
    );

    ptw_pte_check #(.PA_W(PA_W)) u_check (
        .pte   (leaf_q),
        .va    (va_q[PA_W-1:0]),
        .shift (page_shift),
        .acc   (acc_q),
        .plv   (plv_q),
        .code  (result),
        .pa    (phys_addr),
        .wr_ok (can_write),
        .ex_ok (can_exec)
    );

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_SEEK;                      // launch
            S_SEEK: state_d = skip_lvl ? S_SEEK : S_REQ;              // skip / fetch
            S_REQ:  state_d = S_WAIT;                                 // issue
            S_WAIT: if (mem_rvalid)
                        state_d = (lvl_q == '0) ? S_DONE : S_SEEK;    // finish / descend
            S_DONE: state_d = S_IDLE;                                 // retire
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // walk datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            va_q   <= '0;
            acc_q  <= '0;
            plv_q  <= '0;
            base_q <= '0;
            lvl_q  <= '0;
            leaf_q <= '0;
        end else begin
            unique case (state_q)
                S_IDLE: if (start) begin
                    va_q   <= vaddr;
                    acc_q  <= access;
                    plv_q  <= priv;
                    base_q <= vaddr[63] ? {root_hi[PA_W-1:PG_LOW], {PG_LOW{1'b0}}}
                                        : {root_lo[PA_W-1:PG_LOW], {PG_LOW{1'b0}}};
                    lvl_q  <= LV_W'(LEVELS - 1);
                end
                S_SEEK: if (skip_lvl) lvl_q <= lvl_q - LV_W'(1);
                S_WAIT: if (mem_rvalid) begin
                    if (lvl_q == '0) begin
                        leaf_q <= mem_rdata;
                    end else begin
                        base_q <= {mem_rdata[PA_W-1:PG_LOW], {PG_LOW{1'b0}}};
                        lvl_q  <= lvl_q - LV_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        mem_req    = (state_q == S_REQ);
        done       = (state_q == S_DONE);
        leaf_pte   = leaf_q;
        page_shift = lvl_off[SH_W-1:0];
    end

    // ---------------- assertions ----------------
    logic rd_pending;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          rd_pending <= 1'b0;
        else if (mem_rvalid) rd_pending <= 1'b0;
        else if (mem_req)    rd_pending <= 1'b1;
    end

    // R5
    one_outstanding_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> !rd_pending);

    // R6
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    entry_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req |-> (mem_addr[2:0] == 3'b000));

    // R7
    ok_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_OK) |->
            (leaf_pte[PTE_VALID] && !(acc_q == ACC_FETCH && leaf_pte[PTE_NOEX])
             && !(acc_q == ACC_STORE && !leaf_pte[PTE_DIRTY])));

    // R8
    ok_exact_priv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && result == RES_OK && leaf_pte[PTE_EXACT]) |->
            (plv_q == leaf_pte[PTE_PLV +: 2]));

    // R10
    idle_after_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!done && !mem_req));
endmodule

// File: tb/ptw_walker_tb.sv
`timescale 1ns/1ps
module ptw_walker_tb;
    localparam int PA_W = 48;
    localparam logic [63:0] PAMASK = (64'd1 << PA_W) - 64'd1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [63:0]       vaddr = '0;
    logic [1:0]        access = '0;
    logic [1:0]        priv = '0;
    logic [PA_W-1:0]   root_lo = '0;
    logic [PA_W-1:0]   root_hi = '0;
    logic [23:0]       lvl_off = '0;
    logic [23:0]       lvl_wid = '0;
    logic              mem_req;
    logic [PA_W-1:0]   mem_addr;
    logic              mem_rvalid = 1'b0;
    logic [63:0]       mem_rdata = '0;
    logic              done;
    logic [2:0]        result;
    logic [63:0]       leaf_pte;
    logic [5:0]        page_shift;
    logic [PA_W-1:0]   phys_addr;
    logic              can_write, can_exec;

    always #4 clk = ~clk;

    ptw_walker #(.PA_W(PA_W), .LEVELS(4)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr),
        .access(access), .priv(priv), .root_lo(root_lo), .root_hi(root_hi),
        .lvl_off(lvl_off), .lvl_wid(lvl_wid), .mem_req(mem_req),
        .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
        .done(done), .result(result), .leaf_pte(leaf_pte),
        .page_shift(page_shift), .phys_addr(phys_addr),
        .can_write(can_write), .can_exec(can_exec)
    );

    int checks = 0;
    int errors = 0;
    int cfg_off [4];
    int cfg_wid [4];
    logic [63:0] resp [8];
    logic [63:0] addr_log [8];
    int nreq = 0;
    int lat = 0;

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic set_cfg(input int o0, input int w0, input int o1, input int w1,
                           input int o2, input int w2, input int o3, input int w3);
        cfg_off[0] = o0; cfg_wid[0] = w0; cfg_off[1] = o1; cfg_wid[1] = w1;
        cfg_off[2] = o2; cfg_wid[2] = w2; cfg_off[3] = o3; cfg_wid[3] = w3;
        for (int k = 0; k < 4; k++) begin
            lvl_off[k*6 +: 6] = 6'(cfg_off[k]);
            lvl_wid[k*6 +: 6] = 6'(cfg_wid[k]);
        end
    endtask

    // memory responder: one response per request, lat+1 cycles later
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req) begin
                int k;
                k = nreq;
                if (nreq < 8) addr_log[nreq] = 64'(mem_addr);
                nreq++;
                repeat (lat + 1) @(negedge clk);
                mem_rvalid = 1'b1;
                mem_rdata  = (k < 8) ? resp[k] : 64'd0;
                @(negedge clk);
                mem_rvalid = 1'b0;
            end
        end
    end

    function automatic logic [2:0] exp_code(input logic [63:0] pte, input int acc,
                                            input int pv);
        logic bad;
        bad = pte[63] ? (pv != int'(pte[3:2])) : (pv > int'(pte[3:2]));
        if (!pte[0])                return 3'd1;
        if (acc == 2 && pte[62])    return 3'd2;
        if (acc == 0 && pte[61])    return 3'd3;
        if (bad)                    return 3'd4;
        if (acc == 1 && !pte[1])    return 3'd5;
        return 3'd0;
    endfunction

    task automatic walk(input logic [63:0] va, input int acc, input int pv,
                        input logic [63:0] leaf, input int lat_i);
        logic [63:0] base, ea, mask, pexp;
        logic [63:0] exp_addr [8];
        int n, t;
        logic [2:0] ec;
        base = (va[63] ? 64'(root_hi) : 64'(root_lo)) & PAMASK & ~64'hFFF;
        n = 0;
        for (int lv = 3; lv >= 0; lv--) begin
            if (lv == 0 || cfg_wid[lv] != 0) begin
                ea = (base + (((va >> cfg_off[lv]) & ((64'd1 << cfg_wid[lv]) - 64'd1)) << 3))
                     & PAMASK;
                exp_addr[n] = ea;
                if (lv != 0) begin
                    resp[n] = 64'hF5A0_0000_0000_0000 ^ (va * 64'(n + 3)) ^ 64'h9E7;
                    base = resp[n] & PAMASK & ~64'hFFF;
                end else begin
                    resp[n] = leaf;
                end
                n++;
            end
        end
        @(negedge clk);
        lat = lat_i; nreq = 0;
        vaddr = va; access = 2'(acc); priv = 2'(pv);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        t = 0;
        while (!done && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R6 done seen", 64'(done), 64'd1);
        // R3: number of reads equals active levels
        chk(nreq == n, "R3 read count", 64'(nreq), 64'(n));
        for (int i = 0; i < n && i < nreq; i++) begin
            if (i == 0) chk(addr_log[i] == exp_addr[i], "R1 root read address", addr_log[i], exp_addr[i]);
            else        chk(addr_log[i] == exp_addr[i], "R2 R4 entry address", addr_log[i], exp_addr[i]);
        end
        chk(leaf_pte == leaf, "R4 leaf unmodified", leaf_pte, leaf);
        chk(64'(page_shift) == 64'(cfg_off[0]), "R6 page_shift", 64'(page_shift), 64'(cfg_off[0]));
        ec = exp_code(leaf, acc, pv);
        chk(result == ec, "R7 R8 result code", 64'(result), 64'(ec));
        mask = (64'd1 << cfg_off[0]) - 64'd1;
        pexp = (((leaf & PAMASK) & ~mask) | (va & mask)) & PAMASK;
        chk(64'(phys_addr) == pexp, "R9 phys_addr", 64'(phys_addr), pexp);
        chk(can_write == leaf[1] && can_exec == !leaf[62], "R9 rights",
            {62'd0, can_write, can_exec}, {62'd0, leaf[1], !leaf[62]});
        @(negedge clk);
        chk(done == 1'b0, "R6 done one cycle", 64'(done), 64'd0);
    endtask

    function automatic logic [63:0] mk_leaf(input int v, input int d, input int nx,
                                            input int nr, input int pl, input int rp,
                                            input logic [63:0] frame);
        return (64'(rp) << 63) | (64'(nx) << 62) | (64'(nr) << 61) |
               (frame & PAMASK & ~64'hFFF) | 64'hA50 | (64'(pl) << 2) |
               (64'(d) << 1) | 64'(v);
    endfunction

    bit finished = 0;

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog actual=%h expected=%h", 64'd0, 64'd1);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        root_lo = 48'h0000_1234_5FFF;
        root_hi = 48'h0000_ABC0_0123;
        set_cfg(12, 9, 21, 9, 30, 9, 39, 9);
        repeat (3) @(negedge clk);
        // R10 reset state
        chk(done == 1'b0 && mem_req == 1'b0, "R10 reset outputs",
            {62'd0, done, mem_req}, 64'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(done == 1'b0 && mem_req == 1'b0, "R10 idle after reset",
            {62'd0, done, mem_req}, 64'd0);

        // exhaustive permission sweep, four-level tree (R7 R8 R9)
        for (int acc = 0; acc < 3; acc++)
            for (int pv = 0; pv < 4; pv++)
                for (int pl = 0; pl < 4; pl++)
                    for (int rp = 0; rp < 2; rp++)
                        for (int f = 0; f < 16; f++)
                            walk(64'h8000_1234_5678_9ABC ^ 64'(f << 13), acc, pv,
                                 mk_leaf(f & 1, (f >> 1) & 1, (f >> 2) & 1, (f >> 3) & 1,
                                         pl, rp, 64'h0000_7654_3210_F000 + 64'(pl << 20)),
                                 f % 3);

        // two-level tree, 16 KiB pages, levels 3 and 2 skipped (R3 R1 R9)
        set_cfg(14, 11, 25, 11, 36, 0, 47, 0);
        for (int i = 0; i < 64; i++)
            walk((64'(i & 1) << 63) ^ (64'(i) * 64'h0000_1357_9BDF_2468), 1, 0,
                 mk_leaf(1, 1, 0, 0, 3, 0, 64'(i) * 64'h0000_0011_1111_7000), i % 3);

        // skipped level between active ones (R3 R2)
        set_cfg(12, 9, 21, 0, 21, 9, 40, 0);
        for (int i = 0; i < 64; i++)
            walk((64'((i >> 1) & 1) << 63) ^ (64'(i) * 64'h0000_2468_ACE1_3579), 2, 2,
                 mk_leaf(1, 0, i & 1, 0, 2, 1, 64'(i) * 64'h0000_0003_0303_5000), (i + 1) % 3);

        finished = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule